// File: doc/BRIEF.md
# DRAM Command Decoder and Bank State Tracker

This block sits on the device side of a DDR2-style SDRAM command bus. On every rising clock edge it samples the chip select, the three active-low strobes (row strobe, column strobe, write enable), the bank address, the address bus and the clock enable. It turns each sample into one command: activate, precharge, read, write, no-operation, deselect or other. It then updates an idle/active flag and an open-row register for each of eight banks.

Illegal accesses are flagged for one cycle and leave the banks untouched. The block publishes a per-bank active vector and an all-idle flag. It also raises a pulse when the clock enable drops while every bank is idle, so that logic around it can qualify a power-down or self-refresh entry. A query port returns the open row of any bank.

A sample is applied only when the clock enable was high at the previous edge. Once the clock enable is seen low, every state register holds from the next edge until the clock enable has been seen high again.

Top module: `dram_cmd_tracker`

## Requirements
- R1: When cs_ni is high at an edge, the sample is a deselect: cmd_o reads 5 and no bank state, open row, col_o or err_o changes.
- R2: cs_ni=0, ras_ni=0, cas_ni=1, we_ni=1 is activate (cmd_o=1). If the bank on ba_i is idle, it becomes active and stores addr_i[12:0] as its open row.
- R3: cs_ni=0, ras_ni=0, cas_ni=1, we_ni=0 with addr_i[10]=0 is a precharge (cmd_o=2) of the bank on ba_i only. That bank goes idle and its open row reads 0. A precharge of an already idle bank is legal and changes nothing.
- R4: A precharge with addr_i[10]=1 closes all eight banks at once.
- R5: cs_ni=0, ras_ni=1, cas_ni=0 is a column access: we_ni=1 is read (cmd_o=3) and we_ni=0 is write (cmd_o=4). A legal access loads col_o with addr_i[9:0]; otherwise col_o holds.
- R6: A legal read or write with addr_i[10]=1 returns its bank to idle after the access (auto-precharge).
- R7: A sample is applied only if cke_i was high at the previous edge. Otherwise cmd_o reads 0 and nothing else changes, including err_o, which stays 0.
- R8: all_idle_o is 1 exactly when no bank is active. pd_entry_o pulses for one cycle after an edge at which cke_i is low, cke_i was high at the previous edge, and all banks are idle after that edge's command.
- R9: cs_ni=0 with ras_ni, cas_ni and we_ni all high is a no-operation (cmd_o=0). Any other strobe pattern with cs_ni low reads cmd_o=6. Neither changes any state.
- R10: A read or write to an idle bank, or an activate to an active bank, sets err_o for the following cycle and changes no bank state or col_o.
- R11: While rst_ni is low, all banks are idle, all open rows and col_o are 0, cmd_o is 0, err_o and pd_entry_o are 0, and the next sample is applied.
- R12: rowq_row_o returns the open row of the bank on rowq_ba_i, and 0 for an idle bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 3 | Bank address |
| addr_i | input | 13 | Row address or column address; bit 10 selects all-bank precharge or auto-precharge |
| rowq_ba_i | input | 3 | Bank whose open row is shown on rowq_row_o |
| cmd_o | output | 3 | Applied command: 0 nop/frozen, 1 act, 2 pre, 3 rd, 4 wr, 5 deselect, 6 other |
| col_o | output | 10 | Column of the last legal read or write |
| err_o | output | 1 | Illegal access at the previous edge |
| bank_active_o | output | 8 | Per-bank active flags, bit n for bank n |
| all_idle_o | output | 1 | No bank active |
| pd_entry_o | output | 1 | Qualified power-down entry pulse |
| rowq_row_o | output | 13 | Open row of the queried bank |

## Verification
The bench targets the edges around a clock-enable drop. A design that freezes one edge early would lose the command sampled with cke_i low. One that resumes one edge early would apply the command sampled as cke_i returns. Both show up as a wrong cmd_o or bank vector. Further cases are all-bank precharge against single-bank precharge, where a design that misreads addr_i[10] leaves banks open or closes the wrong ones. The bench also covers auto-precharge on a read or write, and activates to open banks and accesses to closed banks. A design that updated state on those would overwrite an open row or open a bank, and a missing error pulse shows as a mismatch on err_o. Power-down entry is tried with one bank still open and with all banks closed, to catch a pulse that ignores bank state.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_DES = 3'd5,
    CMD_OTH = 3'd6
  } cmd_e;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_DES;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = CMD_PRE;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_OTH;
      endcase
    end
  end
endmodule

// File: rtl/dct_bank_table.sv
module dct_bank_table #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] set_mask_i,
  input  logic [NUM_BANKS-1:0] clr_mask_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [BA_W-1:0]      rowq_ba_i,
  output logic [NUM_BANKS-1:0] active_o,
  output logic [ROW_W-1:0]     rowq_row_o
);
  logic [ROW_W-1:0] row_q [NUM_BANKS];

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        active_o[i] <= 1'b0;
        row_q[i]    <= '0;
      end else if (set_mask_i[i]) begin
        active_o[i] <= 1'b1;
        row_q[i]    <= row_i;
      end else if (clr_mask_i[i]) begin
        active_o[i] <= 1'b0;
        row_q[i]    <= '0;
      end
    end

    AST_OPEN_ON_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_mask_i[i] |=> active_o[i]); // R2
    AST_CLOSE_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_mask_i[i] && !set_mask_i[i]) |=> !active_o[i]); // R3
  end

  assign rowq_row_o = row_q[rowq_ba_i];
endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ROW_W-1:0]     addr_i,
  input  logic [BA_W-1:0]      rowq_ba_i,
  output logic [2:0]           cmd_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 err_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic                 all_idle_o,
  output logic                 pd_entry_o,
  output logic [ROW_W-1:0]     rowq_row_o
);
  cmd_e                 cmd_dec, cmd_eff;
  logic                 cke_q;
  logic                 sel_active, col_acc, err_d, legal_col, ap;
  logic [NUM_BANKS-1:0] bank_onehot, set_mask, clr_mask, active_next;

  dct_decode u_decode (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd_dec)
  );

  // state only advances when CKE was high at the previous edge
  assign cmd_eff     = cke_q ? cmd_dec : CMD_NOP;
  assign bank_onehot = NUM_BANKS'(1) << ba_i;
  assign sel_active  = |(bank_active_o & bank_onehot);
  assign col_acc     = (cmd_eff == CMD_RD) || (cmd_eff == CMD_WR);
  assign ap          = addr_i[AP_BIT];
  assign err_d       = (col_acc && !sel_active) || ((cmd_eff == CMD_ACT) && sel_active);
  assign legal_col   = col_acc && sel_active;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (cmd_eff == CMD_ACT && !sel_active) set_mask = bank_onehot;
    if (cmd_eff == CMD_PRE) clr_mask = ap ? '1 : bank_onehot;
    if (legal_col && ap) clr_mask = bank_onehot;
  end

  assign active_next = (bank_active_o | set_mask) & ~(clr_mask & ~set_mask);

  dct_bank_table #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .row_i      (addr_i),
    .rowq_ba_i  (rowq_ba_i),
    .active_o   (bank_active_o),
    .rowq_row_o (rowq_row_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b1;
      cmd_o      <= CMD_NOP;
      col_o      <= '0;
      err_o      <= 1'b0;
      pd_entry_o <= 1'b0;
    end else begin
      cke_q      <= cke_i;
      cmd_o      <= cmd_eff;
      err_o      <= err_d;
      pd_entry_o <= cke_q && !cke_i && (active_next == '0);
      if (legal_col) col_o <= addr_i[COL_W-1:0];
    end
  end

  assign all_idle_o = ~|bank_active_o;

  AST_DESELECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(bank_active_o) && !err_o)); // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_q |=> ($stable(bank_active_o) && $stable(col_o) && !err_o)); // R7
  AST_ERR_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (bank_active_o == $past(bank_active_o))); // R10
  AST_PD_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_entry_o |-> all_idle_o); // R8
endmodule

// File: tb/dram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module dram_cmd_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0, rowq = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmd;
  logic [9:0]  col;
  logic        err, all_idle, pd;
  logic [7:0]  act;
  logic [12:0] rowq_row;

  int checks = 0, fails = 0;

  // reference model
  bit          m_act [8];
  int          m_row [8];
  int          m_col, m_cmd;
  bit          m_err, m_pd, m_cke_q;

  always #2 clk = ~clk;

  dram_cmd_tracker u_dram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .rowq_ba_i(rowq),
    .cmd_o(cmd), .col_o(col), .err_o(err), .bank_active_o(act),
    .all_idle_o(all_idle), .pd_entry_o(pd), .rowq_row_o(rowq_row)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int m_mask();
    int v = 0;
    for (int i = 0; i < 8; i++) if (m_act[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_row[i] = 0; end
    m_col = 0; m_cmd = 0; m_err = 0; m_pd = 0; m_cke_q = 1;
  endtask

  task automatic m_step();
    int  dec, eff;
    bit  selact;
    if (cs_n) dec = 5;
    else if ({ras_n, cas_n, we_n} == 3'b011) dec = 1;
    else if ({ras_n, cas_n, we_n} == 3'b010) dec = 2;
    else if ({ras_n, cas_n, we_n} == 3'b101) dec = 3;
    else if ({ras_n, cas_n, we_n} == 3'b100) dec = 4;
    else if ({ras_n, cas_n, we_n} == 3'b111) dec = 0;
    else dec = 6;
    eff = m_cke_q ? dec : 0;
    selact = m_act[ba];
    m_err = ((eff == 3 || eff == 4) && !selact) || (eff == 1 && selact);
    if (eff == 1 && !selact) begin m_act[ba] = 1; m_row[ba] = addr; end
    if (eff == 2) begin
      if (addr[10]) for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_row[i] = 0; end
      else begin m_act[ba] = 0; m_row[ba] = 0; end
    end
    if ((eff == 3 || eff == 4) && selact) begin
      m_col = addr[9:0];
      if (addr[10]) begin m_act[ba] = 0; m_row[ba] = 0; end
    end
    m_pd = m_cke_q && !cke && (m_mask() == 0);
    m_cmd = eff;
    m_cke_q = cke;
  endtask

  task automatic compare_all();
    chk("R2 bank vector", act, m_mask());
    chk("R5 cmd", cmd, m_cmd);
    chk("R5 col", col, m_col);
    chk("R10 err", err, m_err);
    chk("R8 all_idle", all_idle, m_mask() == 0);
    chk("R8 pd_entry", pd, m_pd);
    chk("R12 row query", rowq_row, m_row[rowq]);
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(bit k, bit cs, bit r, bit c, bit w, int b, int a);
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = 3'(b); addr = 13'(a);
    @(posedge clk);
    m_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic t_act(int b, int a); step(1, 0, 0, 1, 1, b, a); endtask
  task automatic t_pre(int b, bit all); step(1, 0, 0, 1, 0, b, all ? 13'h400 : 0); endtask
  task automatic t_rd(int b, int a); step(1, 0, 1, 0, 1, b, a); endtask
  task automatic t_wr(int b, int a); step(1, 0, 1, 0, 0, b, a); endtask
  task automatic t_nop(); step(1, 0, 1, 1, 1, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 banks", act, 0); chk("R11 cmd", cmd, 0); chk("R11 col", col, 0);
    chk("R11 err", err, 0); chk("R11 idle", all_idle, 1); chk("R11 pd", pd, 0);
    chk("R11 row", rowq_row, 0);
    rst_n = 1'b1;
    @(negedge clk);

    rowq = 3;
    t_act(3, 13'h1abc);                        // R2
    chk("R2 row stored", rowq_row, 13'h1abc);
    t_act(3, 13'h0111);                        // R10 act on active bank
    chk("R10 err act", err, 1);
    chk("R10 row kept", rowq_row, 13'h1abc);
    t_rd(5, 13'h0055);                         // R10 read idle bank
    chk("R10 err rd", err, 1);
    t_rd(3, 13'h0123);                         // R5 read
    chk("R5 rd cmd", cmd, 3); chk("R5 rd col", col, 13'h123 & 13'h3ff);
    t_wr(3, 13'h0077);
    chk("R5 wr cmd", cmd, 4);
    step(1, 1, 0, 1, 1, 3, 0);                 // R1 deselect looking like act
    chk("R1 deselect", cmd, 5); chk("R1 bank kept", act, 8'h08);
    step(1, 0, 0, 0, 0, 3, 13'h400);           // R9 other pattern
    chk("R9 other", cmd, 6); chk("R9 bank kept", act, 8'h08);
    t_nop();
    chk("R9 nop", cmd, 0);
    t_wr(3, 13'h0402);                         // R6 auto-precharge
    chk("R6 ap closes", act, 0); chk("R6 row cleared", rowq_row, 0);
    t_act(0, 1); t_act(1, 2); t_act(7, 3);
    t_pre(1, 0);                               // R3 single
    chk("R3 single", act, 8'h81);
    t_pre(1, 0);
    chk("R3 idle pre legal", err, 0);
    t_pre(2, 1);                               // R4 all
    chk("R4 all", act, 0);
    // R7 freeze: cmd at cke-low edge still applies, then frozen
    t_act(2, 9);
    step(0, 0, 0, 1, 1, 4, 44);                // applied; bank 2 open so no pd
    chk("R7 last applied", act, 8'h14); chk("R8 no pd open", pd, 0);
    step(0, 0, 0, 1, 1, 5, 55);
    chk("R7 frozen cmd", cmd, 0); chk("R7 frozen banks", act, 8'h14);
    step(1, 0, 0, 1, 1, 6, 66);                // still frozen (cke_q low)
    chk("R7 exit edge", act, 8'h14);
    t_pre(0, 1);
    step(0, 0, 1, 1, 1, 0, 0);                 // R8 pd with all idle
    chk("R8 pd pulse", pd, 1);
    step(0, 0, 1, 1, 1, 0, 0);
    chk("R8 pd one cycle", pd, 0);
    step(1, 0, 1, 1, 1, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      rowq = 3'($urandom);
      step(($urandom % 10) != 0, ($urandom % 7) == 0, 1'($urandom), 1'($urandom),
           1'($urandom), $urandom % 8, $urandom);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule